// File: doc/BRIEF.md
# Oscillator Control and Trim Register

This block is the software-visible control word for an off-chip high-speed oscillator and an on-chip RC oscillator. A single 32-bit word holds the external oscillator enable, its pass-through (bypass) enable, a ready flag that only hardware sets, two clock-monitor enables, a calibration byte and a 5-bit software trim. The analog oscillators sit outside the block. They receive the enables and the combined trim code.

Writes follow interlocks that depend on how the clock is being used at that moment. The bypass setting can only change while the oscillator is off. The oscillator cannot be switched off by software while it drives the system clock or feeds the PLL. A low-power entry request turns it off in hardware. The ready flag rises after a programmable number of oscillator ticks counted from the enable. The RC trim code is the calibration byte plus the software adjustment, clamped at full scale.

Top module: `osc_ctl_reg`

## Requirements
- R1: While `rst_n` is low on a clock edge, every control bit and the adjustment field are cleared and `cal_value` is captured as the calibration byte. After reset, `rd_data` shows only the calibration byte.
- R2: `rd_data` layout: bit 16 oscillator enable, bit 17 ready flag, bit 18 bypass, bit 19 oscillator monitor enable, bit 20 PLL monitor enable, bits 15:8 calibration byte, bits 7:3 trim adjustment. All other bits read 0.
- R3: A write (`wr_en` high at a clock edge) updates bits 19, 20 and 7:3 from `wr_data` at that edge. The monitor-enable outputs follow bits 19 and 20.
- R4: A write updates the bypass bit only when the oscillator enable was 0 before that edge. Otherwise the bypass bit keeps its value.
- R5: A write of 0 to bit 16 has no effect while the enable is 1 and `sys_src_ext` or `pll_src_ext` is high.
- R6: `lowpwr_entry` high at an edge clears the oscillator enable at that edge. This overrides any write and the in-use hold.
- R7: The ready flag, the calibration byte and the reserved bits ignore writes.
- R8: With the enable set and a limit of N, the ready flag rises one edge after the N-th `osc_tick` pulse has been counted. Only edges with `osc_tick` high advance the count. With N = 0 the flag rises at the first edge after the enable.
- R9: The ready flag reads 0 in every cycle in which the enable is 0. A later enable restarts the count from zero.
- R10: `trim_code` equals calibration byte plus adjustment, clamped to all ones when the sum exceeds the output width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| sys_src_ext | input | 1 | External oscillator is the system clock |
| pll_src_ext | input | 1 | External oscillator is the PLL input |
| lowpwr_entry | input | 1 | Deep-sleep or standby entry request |
| osc_tick | input | 1 | One pulse per counted oscillator cycle |
| stab_limit | input | CNT_W | Ticks needed before the ready flag rises |
| cal_value | input | 8 | Factory calibration byte, captured in reset |
| ext_en | output | 1 | External oscillator enable |
| ext_bypass | output | 1 | Pass the input clock straight through |
| ext_mon_en | output | 1 | External oscillator monitor enable |
| pll_mon_en | output | 1 | PLL clock monitor enable |
| ext_ready | output | 1 | Oscillator ready flag |
| trim_code | output | TRIM_W | Clamped RC trim code |

## Verification
The hardest state to reach is a ready flag that is already high when software issues a write that tries to clear it, or clears the enable and immediately sets it again. The bench keeps `osc_tick` high with a small limit so that the flag rises a known number of edges after the enable. It then writes into bit 17 and checks that the flag is unchanged. Next it clears and re-enables in back-to-back cycles and checks that the flag stays low until a fresh count completes. The clamp is reached by reloading a high calibration byte through reset and stepping the adjustment across the overflow point.

// File: rtl/osc_ctl_pkg.sv
// Shared field positions and widths of the oscillator control word.
// Assumes a 32-bit register; positions that software decodes are fixed here.
package osc_ctl_pkg;
    localparam int DATA_W   = 32;
    localparam int CAL_W    = 8;
    localparam int ADJ_W    = 5;
    localparam int EN_BIT   = 16;
    localparam int RDY_BIT  = 17;
    localparam int BYP_BIT  = 18;
    localparam int XMON_BIT = 19;
    localparam int PMON_BIT = 20;
    localparam int ADJ_LSB  = 3;
    localparam int CAL_LSB  = 8;
    localparam logic [DATA_W-1:0] RSVD_MASK = 32'hFFE0_0007;
endpackage

// File: rtl/osc_stab_timer.sv
// Counts oscillator ticks after the enable and raises a ready flag once the
// programmed limit is reached. Assumes limit is steady while counting.
module osc_stab_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             ready
);
    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;

    // Count ticks while enabled and not yet ready; restart when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (!rdy_q) begin
            if (cnt_q >= limit) begin
                rdy_q <= 1'b1;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready = rdy_q;

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rdy_q && tick && (cnt_q < limit)) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R8
    rdy_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> ($past(cnt_q) >= $past(limit)));
    // R9
    rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rdy_q);
endmodule

// File: rtl/osc_trim_sum.sv
// Adds calibration byte and software adjustment and clamps the result to the
// all-ones value of the output width instead of wrapping.
module osc_trim_sum #(
    parameter int CAL_W  = 8,
    parameter int ADJ_W  = 5,
    parameter int TRIM_W = 8
) (
    input  logic [CAL_W-1:0]  cal,
    input  logic [ADJ_W-1:0]  adj,
    output logic [TRIM_W-1:0] trim
);
    localparam int SUM_W = ((CAL_W > ADJ_W) ? CAL_W : ADJ_W) + 1;
    localparam int W     = (SUM_W > TRIM_W) ? SUM_W : TRIM_W;
    localparam logic [W-1:0] LIM = W'({TRIM_W{1'b1}});

    logic [W-1:0] sum;

    // Widen both operands, add, then clamp at full scale.
    always_comb begin
        sum  = W'(cal) + W'(adj);
        trim = (sum > LIM) ? LIM[TRIM_W-1:0] : sum[TRIM_W-1:0];
    end
endmodule

// File: rtl/osc_ctl_reg.sv
// Control word for an external oscillator and a trimmed RC oscillator.
// Applies the bypass lock, the in-use hold on the enable and the low-power
// clear; assumes source-select and low-power inputs are synchronous to clk.
module osc_ctl_reg
    import osc_ctl_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sys_src_ext,
    input  logic              pll_src_ext,
    input  logic              lowpwr_entry,
    input  logic              osc_tick,
    input  logic [CNT_W-1:0]  stab_limit,
    input  logic [CAL_W-1:0]  cal_value,
    output logic              ext_en,
    output logic              ext_bypass,
    output logic              ext_mon_en,
    output logic              pll_mon_en,
    output logic              ext_ready,
    output logic [TRIM_W-1:0] trim_code
);
    logic             en_q, byp_q, xmon_q, pmon_q;
    logic [CAL_W-1:0] cal_q;
    logic [ADJ_W-1:0] adj_q;
    logic             in_use;
    logic             rdy_raw;

    assign in_use = en_q && (sys_src_ext || pll_src_ext);

    // Register update with interlocks; calibration captured during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            byp_q  <= 1'b0;
            xmon_q <= 1'b0;
            pmon_q <= 1'b0;
            adj_q  <= '0;
            cal_q  <= cal_value;
        end else begin
            if (lowpwr_entry) begin
                en_q <= 1'b0;
            end else if (wr_en && (wr_data[EN_BIT] || !in_use)) begin
                en_q <= wr_data[EN_BIT];
            end
            if (wr_en) begin
                if (!en_q) begin
                    byp_q <= wr_data[BYP_BIT];
                end
                xmon_q <= wr_data[XMON_BIT];
                pmon_q <= wr_data[PMON_BIT];
                adj_q  <= wr_data[ADJ_LSB +: ADJ_W];
            end
        end
    end

    osc_stab_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .tick  (osc_tick),
        .limit (stab_limit),
        .ready (rdy_raw)
    );

    osc_trim_sum #(.CAL_W(CAL_W), .ADJ_W(ADJ_W), .TRIM_W(TRIM_W)) u_trim (
        .cal  (cal_q),
        .adj  (adj_q),
        .trim (trim_code)
    );

    // Ready flag is masked by the live enable so it drops in the same cycle.
    assign ext_ready  = rdy_raw && en_q;
    assign ext_en     = en_q;
    assign ext_bypass = byp_q;
    assign ext_mon_en = xmon_q;
    assign pll_mon_en = pmon_q;

    // Assemble the read word; unlisted bits stay zero.
    always_comb begin
        rd_data                      = '0;
        rd_data[EN_BIT]              = en_q;
        rd_data[RDY_BIT]             = ext_ready;
        rd_data[BYP_BIT]             = byp_q;
        rd_data[XMON_BIT]            = xmon_q;
        rd_data[PMON_BIT]            = pmon_q;
        rd_data[CAL_LSB +: CAL_W]    = cal_q;
        rd_data[ADJ_LSB +: ADJ_W]    = adj_q;
    end

    // R4
    bypass_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && en_q) |=> $stable(byp_q));
    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_use && !lowpwr_entry) |=> en_q);
    // R6
    lowpwr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_entry |=> !ext_en);
    // R7
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & RSVD_MASK) != '0)) |=> ((rd_data & RSVD_MASK) == '0));
    // R7
    cal_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[CAL_LSB +: CAL_W] != cal_q)) |=> $stable(cal_q));
    // R7
    rdy_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[RDY_BIT] && !ext_ready && en_q) |=> !ext_ready);
    // R10
    trim_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ({1'b0, trim_code} >= (TRIM_W+1)'(cal_q)));
endmodule

// File: tb/osc_ctl_reg_test.sv
`timescale 1ns/1ps
module osc_ctl_reg_test;
    localparam int CNT_W = 16;
    localparam int TRIM_W = 8;
    localparam int NVEC = 11;

    // {wr, sys, pll, lp, wdata[31:0], expected rd[31:0]} ; calibration = A5
    localparam logic [67:0] VEC [NVEC] = '{
        {4'b1000, 32'h0004_0000, 32'h0004_A500}, // R4 bypass while off
        {4'b1000, 32'h0005_0000, 32'h0005_A500}, // R4 enable + bypass
        {4'b1000, 32'h0001_0000, 32'h0005_A500}, // R4 locked
        {4'b1100, 32'h0000_0000, 32'h0005_A500}, // R5 system clock hold
        {4'b1010, 32'h0000_0000, 32'h0005_A500}, // R5 PLL input hold
        {4'b1000, 32'h0000_0000, 32'h0004_A500}, // R5 released, R4 locked
        {4'b1000, 32'h0000_0000, 32'h0000_A500}, // R4 bypass clears
        {4'b1000, 32'hFFFF_FFFF, 32'h001D_A5F8}, // R3 R7 all ones
        {4'b1101, 32'h0000_0000, 32'h0004_A500}, // R6 overrides hold
        {4'b1001, 32'h0001_0000, 32'h0000_A500}, // R6 overrides write
        {4'b0000, 32'hFFFF_FFFF, 32'h0000_A500}  // R2 no strobe
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              sys_src_ext = 1'b0, pll_src_ext = 1'b0, lowpwr_entry = 1'b0;
    logic              osc_tick = 1'b0;
    logic [CNT_W-1:0]  stab_limit = 16'd3;
    logic [7:0]        cal_value = 8'hA5;
    logic              ext_en, ext_bypass, ext_mon_en, pll_mon_en, ext_ready;
    logic [TRIM_W-1:0] trim_code;
    int                checks = 0;
    int                failures = 0;

    always #2.5 clk = ~clk;

    osc_ctl_reg #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sys_src_ext(sys_src_ext), .pll_src_ext(pll_src_ext),
        .lowpwr_entry(lowpwr_entry), .osc_tick(osc_tick), .stab_limit(stab_limit),
        .cal_value(cal_value), .ext_en(ext_en), .ext_bypass(ext_bypass),
        .ext_mon_en(ext_mon_en), .pll_mon_en(pll_mon_en), .ext_ready(ext_ready),
        .trim_code(trim_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, then return at the next falling edge.
    task automatic step(input logic w, input logic [31:0] d, input logic s,
                        input logic p, input logic l);
        wr_en = w; wr_data = d; sys_src_ext = s; pll_src_ext = p; lowpwr_entry = l;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; sys_src_ext = 1'b0; pll_src_ext = 1'b0; lowpwr_entry = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] cal);
        cal_value = cal;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(8'hA5);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0000_A500);
        chk("R1 outputs", {27'd0, ext_en, ext_bypass, ext_mon_en, pll_mon_en, ext_ready}, 32'd0);
        chk("R1 trim", 32'(trim_code), 32'hA5);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][67], VEC[i][63:32], VEC[i][66], VEC[i][65], VEC[i][64]);
            chk($sformatf("R2 vec %0d rd_data", i), rd_data, VEC[i][31:0]);
            chk($sformatf("R3 vec %0d outputs", i),
                {28'd0, ext_en, ext_bypass, ext_mon_en, pll_mon_en},
                {28'd0, VEC[i][16], VEC[i][18], VEC[i][19], VEC[i][20]});
        end

        // R3 R10 adjustment updates trim without clamping
        step(1'b1, 32'h0000_00F8, 1'b0, 1'b0, 1'b0);
        chk("R3 adj readback", rd_data, 32'h0000_A5F8);
        chk("R10 trim sum", 32'(trim_code), 32'hC4);

        // R10 clamp at the boundary
        do_reset(8'hF0);
        chk("R1 cal reload", rd_data, 32'h0000_F000);
        step(1'b1, 32'h0000_0070, 1'b0, 1'b0, 1'b0);
        chk("R10 below limit", 32'(trim_code), 32'hFE);
        step(1'b1, 32'h0000_0078, 1'b0, 1'b0, 1'b0);
        chk("R10 at limit", 32'(trim_code), 32'hFF);
        step(1'b1, 32'h0000_0080, 1'b0, 1'b0, 1'b0);
        chk("R10 over limit", 32'(trim_code), 32'hFF);
        step(1'b1, 32'h0000_00F8, 1'b0, 1'b0, 1'b0);
        chk("R10 max adj", 32'(trim_code), 32'hFF);

        // R8 ready timing with ticks every cycle, limit 3
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        osc_tick = 1'b1; stab_limit = 16'd3;
        step(1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
        chk("R8 not ready at enable", 32'(ext_ready), 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 not ready after 3 edges", 32'(rd_data[17]), 32'd0);
        @(negedge clk);
        chk("R8 ready after 4 edges", 32'(ext_ready), 32'd1);
        chk("R2 ready bit", rd_data, 32'h0003_F000);

        // R7 write of 0 to bit 17 leaves the flag
        step(1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
        chk("R7 ready kept", 32'(rd_data[17]), 32'd1);

        // R9 drop with the enable, restart on re-enable
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        chk("R9 ready drops", 32'(ext_ready), 32'd0);
        step(1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
        chk("R9 restart low", 32'(rd_data[17]), 32'd0);
        osc_tick = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 no ticks no ready", 32'(ext_ready), 32'd0);

        // R8 zero limit
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        stab_limit = 16'd0;
        step(1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
        chk("R8 zero limit first edge", 32'(ext_ready), 32'd0);
        @(negedge clk);
        chk("R8 zero limit ready", 32'(ext_ready), 32'd1);

        // R6 low-power clears a ready, in-use oscillator
        step(1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b1);
        chk("R6 lowpwr clear", {30'd0, ext_en, ext_ready}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule